// File: doc/BRIEF.md
# Sleep Instruction Disable Latch

This block decides whether a processor's two sleep instructions, STOP and WAIT, are honoured. Software disables each instruction through one control register. The disable is either temporary, meaning it can be set and cleared freely, or permanent, meaning it stays set until the next system reset. For each instruction, the effective disable is the OR of a sticky flop and a rewritable flop.

The core raises a request when it executes a sleep instruction. The block passes that request on as a grant only when the instruction is not disabled. When the instruction is disabled, the block drops the request and raises a one-cycle ignored pulse instead. Reading the control register returns all four flops. This lets software see whether a permanent lock is already in place.

Control register fields: bit 0 is STOP permanent, bit 1 is STOP temporary, bit 2 is WAIT permanent and bit 3 is WAIT temporary. Bits above 3 are written as don't-care and read as zero.

Top module: `sleep_disable_ctrl`

## Requirements
- R1: After reset all four disable flops are 0, both disable outputs are low, and a read of the control address returns 0.
- R2: A write to `CTRL_ADDR` with a permanent bit (bit 0 STOP, bit 2 WAIT) at 1 sets that permanent flop. The new value is visible on readback and on the disable output from the cycle after the write edge.
- R3: Once set, a permanent flop ignores any later write of 0 and stays 1 until reset.
- R4: Every write to `CTRL_ADDR` loads each temporary flop (bit 1 STOP, bit 3 WAIT) with the written bit, so it can be both set and cleared.
- R5: Each disable output is the OR of that instruction's permanent and temporary flops.
- R6: While an instruction is disabled, its request produces no grant and an ignored pulse in the same cycle.
- R7: While an instruction is enabled, its request produces a grant and no ignored pulse.
- R8: A write cycle to any address other than `CTRL_ADDR`, or address activity without `reg_wr`, leaves all four flops unchanged.
- R9: A read of `CTRL_ADDR` returns the four flops in bits 3..0 with the upper bits zero. A read of any other address returns 0.
- R10: The STOP and WAIT paths are independent: writing one instruction's bits never changes the other's disable or grant.
- R11: Reset clears a permanent disable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | ADDR_W | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data (combinational on address) |
| stop_req | input | 1 | Core executes STOP |
| wait_req | input | 1 | Core executes WAIT |
| stop_grant | output | 1 | STOP request passed on |
| wait_grant | output | 1 | WAIT request passed on |
| stop_ignored | output | 1 | STOP request dropped |
| wait_ignored | output | 1 | WAIT request dropped |
| stop_disable | output | 1 | STOP disable to core |
| wait_disable | output | 1 | WAIT disable to core |

## Verification
The assertions check on every cycle that:
- a permanent flop never falls outside reset;
- a decoded write sets the permanent flop and loads the temporary flop;
- with no decoded write, the temporary flop holds its value;
- a miss-addressed write changes nothing;
- the grant and ignored outputs are exclusive and follow the effective disable.

Only the bench scenarios can show the rest:
- the exact register bit positions seen through readback;
- that reset actually clears a permanent lock;
- that a write aimed at one instruction leaves the other usable.

// File: rtl/sleepdis_pkg.sv
package sleepdis_pkg;
  localparam int unsigned NUM_INSTR  = 2;
  localparam int unsigned IDX_STOP   = 0;
  localparam int unsigned IDX_WAIT   = 1;
  localparam int unsigned FIELD_BITS = 2;
  localparam int unsigned USED_BITS  = NUM_INSTR * FIELD_BITS;

  function automatic int unsigned perm_pos(input int unsigned idx);
    return idx * FIELD_BITS;
  endfunction

  function automatic int unsigned temp_pos(input int unsigned idx);
    return idx * FIELD_BITS + 1;
  endfunction

  function automatic logic eff_disable(input logic perm, input logic temp);
    return perm | temp;
  endfunction
endpackage

// File: rtl/sleepdis_cell.sv
module sleepdis_cell
  import sleepdis_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic wr_hit,
  input  logic wr_perm,
  input  logic wr_temp,
  input  logic req,
  output logic perm_q,
  output logic temp_q,
  output logic disable_o,
  output logic grant,
  output logic ignored
);
  logic perm_set_ev;
  assign perm_set_ev = wr_hit & wr_perm;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      perm_q <= 1'b0;
      temp_q <= 1'b0;
    end else begin
      if (perm_set_ev) perm_q <= 1'b1;
      if (wr_hit)      temp_q <= wr_temp;
    end
  end

  assign disable_o = eff_disable(perm_q, temp_q);
  assign grant     = req & ~disable_o;
  assign ignored   = req & disable_o;

  AST_PERM_SET: assert property (@(posedge clk) disable iff (!rst_n)
    perm_set_ev |=> perm_q) else $error("perm set");                    // R2
  AST_PERM_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    perm_q |=> perm_q) else $error("perm sticky");                      // R3
  AST_TEMP_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit |=> (temp_q == $past(wr_temp))) else $error("temp load");    // R4
  AST_TEMP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_hit |=> $stable(temp_q)) else $error("temp hold");              // R8
  AST_DROP_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (req && (perm_q || temp_q)) |-> (ignored && !grant)) else $error("drop"); // R6
  AST_PASS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !perm_q && !temp_q) |-> (grant && !ignored)) else $error("pass"); // R7
endmodule

// File: rtl/sleepdis_regif.sv
module sleepdis_regif
  import sleepdis_pkg::*;
#(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned DATA_W    = 16,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'h10
)(
  input  logic [ADDR_W-1:0]    reg_addr,
  input  logic                 reg_wr,
  input  logic [DATA_W-1:0]    reg_wdata,
  input  logic [NUM_INSTR-1:0] perm_q,
  input  logic [NUM_INSTR-1:0] temp_q,
  output logic                 wr_hit,
  output logic [NUM_INSTR-1:0] wr_perm,
  output logic [NUM_INSTR-1:0] wr_temp,
  output logic [DATA_W-1:0]    reg_rdata
);
  logic addr_hit;
  logic [USED_BITS-1:0] packed_state;

  assign addr_hit = (reg_addr == CTRL_ADDR);
  assign wr_hit   = addr_hit & reg_wr;

  for (genvar i = 0; i < NUM_INSTR; i++) begin : g_field
    assign wr_perm[i] = reg_wdata[perm_pos(i)];
    assign wr_temp[i] = reg_wdata[temp_pos(i)];
    assign packed_state[perm_pos(i)] = perm_q[i];
    assign packed_state[temp_pos(i)] = temp_q[i];
  end

  always_comb begin
    reg_rdata = '0;
    if (addr_hit) reg_rdata[USED_BITS-1:0] = packed_state;
  end
endmodule

// File: rtl/sleep_disable_ctrl.sv
module sleep_disable_ctrl
  import sleepdis_pkg::*;
#(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned DATA_W    = 16,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'h10
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              stop_req,
  input  logic              wait_req,
  output logic              stop_grant,
  output logic              wait_grant,
  output logic              stop_ignored,
  output logic              wait_ignored,
  output logic              stop_disable,
  output logic              wait_disable
);
  logic                 wr_hit;
  logic [NUM_INSTR-1:0] wr_perm, wr_temp, perm_q, temp_q;
  logic [NUM_INSTR-1:0] req_v, grant_v, ign_v, dis_v;

  assign req_v[IDX_STOP] = stop_req;
  assign req_v[IDX_WAIT] = wait_req;

  sleepdis_regif #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_ADDR(CTRL_ADDR)) u_regif (
    .reg_addr (reg_addr),
    .reg_wr   (reg_wr),
    .reg_wdata(reg_wdata),
    .perm_q   (perm_q),
    .temp_q   (temp_q),
    .wr_hit   (wr_hit),
    .wr_perm  (wr_perm),
    .wr_temp  (wr_temp),
    .reg_rdata(reg_rdata)
  );

  for (genvar i = 0; i < NUM_INSTR; i++) begin : g_cell
    sleepdis_cell u_cell (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_hit   (wr_hit),
      .wr_perm  (wr_perm[i]),
      .wr_temp  (wr_temp[i]),
      .req      (req_v[i]),
      .perm_q   (perm_q[i]),
      .temp_q   (temp_q[i]),
      .disable_o(dis_v[i]),
      .grant    (grant_v[i]),
      .ignored  (ign_v[i])
    );
  end

  assign stop_grant   = grant_v[IDX_STOP];
  assign wait_grant   = grant_v[IDX_WAIT];
  assign stop_ignored = ign_v[IDX_STOP];
  assign wait_ignored = ign_v[IDX_WAIT];
  assign stop_disable = dis_v[IDX_STOP];
  assign wait_disable = dis_v[IDX_WAIT];

  AST_MISS_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr != CTRL_ADDR) |=> ($stable(perm_q) && $stable(temp_q)))
    else $error("miss write changed state");                            // R8
  AST_GRANT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({stop_grant, stop_ignored}) && $onehot0({wait_grant, wait_ignored}))
    else $error("grant and ignored together");                          // R6
  AST_NO_REQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!stop_req && !wait_req) |-> !(stop_grant || wait_grant || stop_ignored || wait_ignored))
    else $error("output without request");                              // R7
endmodule

// File: tb/sleep_disable_ctrl_tb.sv
module sleep_disable_ctrl_tb;
  localparam int unsigned ADDR_W = 8;
  localparam int unsigned DATA_W = 16;
  localparam logic [ADDR_W-1:0] CTRL = 8'h10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [ADDR_W-1:0] reg_addr = '0;
  logic reg_wr = 1'b0;
  logic [DATA_W-1:0] reg_wdata = '0;
  logic [DATA_W-1:0] reg_rdata;
  logic stop_req = 1'b0, wait_req = 1'b0;
  logic stop_grant, wait_grant, stop_ignored, wait_ignored, stop_disable, wait_disable;

  int checks = 0;
  int errors = 0;
  logic m_sp, m_st, m_wp, m_wt;

  always #2 clk = ~clk;

  sleep_disable_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_ADDR(CTRL)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .stop_req(stop_req), .wait_req(wait_req),
    .stop_grant(stop_grant), .wait_grant(wait_grant),
    .stop_ignored(stop_ignored), .wait_ignored(wait_ignored),
    .stop_disable(stop_disable), .wait_disable(wait_disable)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Readback layout per requirement R9: {wait_temp, wait_perm, stop_temp, stop_perm}
  function automatic logic [DATA_W-1:0] model_rd();
    logic [DATA_W-1:0] v = '0;
    v[3:0] = {m_wt, m_wp, m_st, m_sp};
    return v;
  endfunction

  task automatic check_state(input string tag);
    reg_addr = CTRL; #1;
    chk({tag, " R9 readback"}, reg_rdata, model_rd());
    chk({tag, " R5 stop_disable"}, stop_disable, m_sp | m_st);
    chk({tag, " R5 wait_disable"}, wait_disable, m_wp | m_wt);
  endtask

  task automatic do_write(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d, input logic wr);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = wr;
    @(posedge clk);
    if (wr && a == CTRL) begin
      m_sp = m_sp | d[0]; m_wp = m_wp | d[2];
      m_st = d[1];        m_wt = d[3];
    end
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic try_sleep(input string tag, input logic s, input logic w);
    @(negedge clk);
    stop_req = s; wait_req = w; #1;
    chk({tag, " R7 stop_grant"},   stop_grant,   s & ~(m_sp | m_st));
    chk({tag, " R6 stop_ignored"}, stop_ignored, s &  (m_sp | m_st));
    chk({tag, " R7 wait_grant"},   wait_grant,   w & ~(m_wp | m_wt));
    chk({tag, " R6 wait_ignored"}, wait_ignored, w &  (m_wp | m_wt));
    stop_req = 1'b0; wait_req = 1'b0;
  endtask

  task automatic apply_reset();
    @(negedge clk); rst_n = 1'b0;
    m_sp = 0; m_st = 0; m_wp = 0; m_wt = 0;
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic t_reset();
    apply_reset();
    check_state("R1 reset");
    try_sleep("R1 reset", 1'b1, 1'b1);
  endtask

  task automatic t_temp();
    do_write(CTRL, 16'h0002, 1'b1);
    check_state("R4 stop temp set");
    try_sleep("R4 stop temp set", 1'b1, 1'b1);
    do_write(CTRL, 16'h0000, 1'b1);
    check_state("R4 stop temp clear");
    try_sleep("R4 stop temp clear", 1'b1, 1'b0);
    do_write(CTRL, 16'h0008, 1'b1);
    check_state("R10 wait temp only");
    try_sleep("R10 wait temp only", 1'b1, 1'b1);
    do_write(CTRL, 16'hFFF0, 1'b1);
    check_state("R9 upper bits ignored");
  endtask

  task automatic t_perm();
    do_write(CTRL, 16'h0001, 1'b1);
    check_state("R2 stop perm");
    try_sleep("R2 stop perm", 1'b1, 1'b1);
    do_write(CTRL, 16'h0000, 1'b1);
    check_state("R3 stop perm sticky");
    do_write(CTRL, 16'h000E, 1'b1);
    check_state("R5 perm and temp");
    do_write(CTRL, 16'h0000, 1'b1);
    check_state("R3 wait perm sticky");
    try_sleep("R3 both locked", 1'b1, 1'b1);
  endtask

  task automatic t_miss();
    apply_reset();
    do_write(CTRL + 8'h1, 16'h000F, 1'b1);
    check_state("R8 other address");
    do_write(CTRL, 16'h000F, 1'b0);
    check_state("R8 no strobe");
    reg_addr = CTRL + 8'h4; #1;
    chk("R9 other address reads zero", reg_rdata, 0);
    do_write(CTRL, 16'h0004, 1'b1);
    check_state("R10 wait perm leaves stop");
    try_sleep("R10 wait perm leaves stop", 1'b1, 1'b1);
  endtask

  task automatic t_reset_clears();
    do_write(CTRL, 16'h0005, 1'b1);
    check_state("R11 before reset");
    apply_reset();
    check_state("R11 after reset");
    try_sleep("R11 after reset", 1'b1, 1'b1);
  endtask

  initial begin
    m_sp = 0; m_st = 0; m_wp = 0; m_wt = 0;
    t_reset();
    t_temp();
    t_perm();
    t_miss();
    t_reset_clears();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule